// File: doc/BRIEF.md
# Back-Porch Automatic Offset Servo

This block closes a digital loop around the offset correction of a three-channel 10-bit video digitizer. Each channel has its own signed target code. While the back-porch reference window is open, the block collects the channel's conversion results. When the window closes, it compares the averaged code with the target. The offset correction for that channel then moves one step, so that over successive lines the back-porch code settles on the target. A ground-clamped channel usually aims at a small code such as 2. A color-difference channel clamped at midscale usually aims near 512.

With the automatic mode switched off, the same control words carry manual offsets, and these go straight through to the offset outputs. The offset words are signed and limited to ±255 LSB, where one LSB of offset shifts the output code by one LSB. The analog offset converter and the gain stage that consume these words are outside the block.

Top module: `bo_offset_servo`

## Requirements
- R1: With `auto_en` low, one cycle later each channel's `ofs_word` slice equals the sign-extended low 9 bits of its `ctl_word` slice. Bits 10:9 are ignored, and the pattern -256 (low bits 0x100) is raised to -255.
- R2: In automatic mode, samples are taken only on cycles where `bp_win` is high, and only the first 2^AVG_LOG2 samples of a window are kept (4 by default). The value compared with the target is the floor of their sum divided by that count.
- R3: The window closes on the first cycle on which `bp_win` is sampled low after being sampled high. If the window holds a full set of samples, the offset changes at that clock edge: down by 1 if the average is above the target, up by 1 if it is below, and unchanged if they are equal. The target is the channel's 11-bit `ctl_word` slice read as two's complement (-1024 to +1023), and it is compared with the unsigned code.
- R4: A window that closes with fewer than a full set of samples leaves the offset unchanged and discards its samples.
- R5: The offset never leaves the range -255 to +255. A step that would cross a limit holds the offset at that limit.
- R6: A channel's `lim_hit` bit goes high when a step request leaves the offset at -255 or +255. The bit then stays high until reset, even in manual mode.
- R7: With a target of 0 in automatic mode, the channel keeps its offset. Its `tgt_bad` bit is high one cycle later and goes low one cycle after the target becomes nonzero or automatic mode is left.
- R8: Channels are independent. Channel i uses bits [i*10 +: 10] of `adc_code`, [i*11 +: 11] of `ctl_word` and [i*9 +: 9] of `ofs_word`.
- R9: Reset (synchronous, active low) sets every offset to 0 and clears `lim_hit` and `tgt_bad`.
- R10: On entry to automatic mode the loop starts from the offset last applied in manual mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Synchronous reset, active low |
| auto_en | input | 1 | 1 = closed loop, 0 = manual offsets |
| bp_win | input | 1 | Back-porch reference window strobe |
| adc_code | input | NUM_CH*CODE_W (30) | Unsigned conversion codes, one slice per channel |
| ctl_word | input | NUM_CH*TGT_W (33) | Per channel: signed target in automatic mode, manual offset in low 9 bits otherwise |
| ofs_word | output | NUM_CH*OFS_W (27) | Signed offset correction per channel |
| lim_hit | output | NUM_CH (3) | Sticky flag: offset reached a limit |
| tgt_bad | output | NUM_CH (3) | Target of 0 programmed in automatic mode |

## Verification
The assertions watch properties that hold on every cycle:
- the offset range;
- steps of at most one LSB in automatic mode;
- no offset motion except on a window-closing edge or under a zero target;
- manual pass-through with the -256 adjustment;
- the stickiness of the limit flags;
- the timing of the invalid-target flag.

Only the bench's line-by-line scenarios can show the rest: the averaging arithmetic with its floor and its cut-off after a full set of samples, the direction of each step against signed and midscale targets, the rejection of short windows, convergence into saturation, and the hand-over from manual to automatic.

// File: rtl/bo_servo_pkg.sv
// Shared constants and types for the back-porch offset servo.
// Assumes: all consumers import this package before their port lists.
package bo_servo_pkg;
    localparam int DEF_CH       = 3;
    localparam int DEF_CODE_W   = 10;
    localparam int DEF_TGT_W    = 11;
    localparam int DEF_OFS_W    = 9;
    localparam int DEF_AVG_LOG2 = 2;

    // Requested movement of one channel's offset at a window close.
    typedef enum logic [1:0] {
        DIR_HOLD = 2'd0,
        DIR_UP   = 2'd1,
        DIR_DOWN = 2'd2
    } dir_e;
endpackage

// File: rtl/bo_bp_avg.sv
// Window accumulator: sums the first 2^AVG_LOG2 codes seen while 'take'
// is high and presents their floor average.
// Assumes: 'clr' is asserted on the cycle the window closes (when 'take' is low).
module bo_bp_avg #(
    parameter int CODE_W   = 10,
    parameter int AVG_LOG2 = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              take,
    input  logic [CODE_W-1:0] code,
    output logic [CODE_W-1:0] avg_o,
    output logic              full_o
);
    localparam int NSMP  = 1 << AVG_LOG2;
    localparam int ACC_W = CODE_W + AVG_LOG2;
    localparam int CNT_W = AVG_LOG2 + 1;

    logic [ACC_W-1:0] acc;
    logic [CNT_W-1:0] cnt;

    // Full once the programmed number of samples has been collected.
    assign full_o = (cnt == CNT_W'(NSMP));
    // Divide by the power-of-two count with a shift (floor).
    assign avg_o  = acc[ACC_W-1:AVG_LOG2];

    // Collect samples until full; clear at window close or in manual mode.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc <= '0;
            cnt <= '0;
        end else if (take && !full_o) begin
            acc <= acc + ACC_W'(code);
            cnt <= cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/bo_dir_cmp.sv
// Compares an unsigned averaged code with a signed target and chooses a step
// direction. A zero target is flagged and always yields a hold.
// Assumes: purely combinational; target is two's complement.
module bo_dir_cmp
    import bo_servo_pkg::*;
#(
    parameter int CODE_W = 10,
    parameter int TGT_W  = 11
) (
    input  logic [CODE_W-1:0] avg,
    input  logic [TGT_W-1:0]  target,
    output dir_e              dir,
    output logic              zero_o
);
    localparam int CMP_W = ((CODE_W > TGT_W) ? CODE_W : TGT_W) + 1;

    logic signed [CMP_W-1:0] a_s;
    logic signed [CMP_W-1:0] t_s;

    // Bring both operands to one signed width.
    assign a_s    = $signed({{(CMP_W-CODE_W){1'b0}}, avg});
    assign t_s    = $signed({{(CMP_W-TGT_W){target[TGT_W-1]}}, target});
    assign zero_o = (target == '0);

    // Above target -> lower the offset; below -> raise it.
    always_comb begin
        if (zero_o)         dir = DIR_HOLD;
        else if (a_s > t_s) dir = DIR_DOWN;
        else if (a_s < t_s) dir = DIR_UP;
        else                dir = DIR_HOLD;
    end
endmodule

// File: rtl/bo_ofs_step.sv
// Per-channel offset register: manual load, saturating single-LSB steps,
// sticky limit flag and invalid-target flag.
// Assumes: 'upd' pulses for one cycle per accepted window.
module bo_ofs_step
    import bo_servo_pkg::*;
#(
    parameter int OFS_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              auto_en,
    input  logic              upd,
    input  dir_e              dir,
    input  logic              tgt_zero,
    input  logic [OFS_W-1:0]  manual,
    output logic [OFS_W-1:0]  ofs_o,
    output logic              lim_o,
    output logic              bad_o
);
    localparam int LIM = (1 << (OFS_W-1)) - 1;
    localparam logic [OFS_W-1:0] HI  = OFS_W'(LIM);
    localparam logic [OFS_W-1:0] LO  = OFS_W'(-LIM);
    localparam logic [OFS_W-1:0] MNEG = {1'b1, {(OFS_W-1){1'b0}}};

    logic [OFS_W-1:0] man_c;
    logic [OFS_W-1:0] nxt;
    logic             hit;

    // Raise the one unsymmetrical manual pattern to the lower limit.
    assign man_c = (manual == MNEG) ? LO : manual;

    // Next value of a requested step, held at the limits.
    always_comb begin
        nxt = ofs_o;
        hit = 1'b0;
        unique case (dir)
            DIR_UP: begin
                if (ofs_o != HI) nxt = ofs_o + OFS_W'(1);
                hit = (nxt == HI);
            end
            DIR_DOWN: begin
                if (ofs_o != LO) nxt = ofs_o - OFS_W'(1);
                hit = (nxt == LO);
            end
            default: begin
                nxt = ofs_o;
                hit = 1'b0;
            end
        endcase
    end

    // Offset, limit and target-valid state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ofs_o <= '0;
            lim_o <= 1'b0;
            bad_o <= 1'b0;
        end else begin
            bad_o <= auto_en && tgt_zero;
            if (!auto_en) begin
                ofs_o <= man_c;
            end else if (upd) begin
                ofs_o <= nxt;
                lim_o <= lim_o | hit;
            end
        end
    end
endmodule

// File: rtl/bo_offset_servo.sv
// Top: closed-loop back-porch offset servo for NUM_CH channels.
// Detects the closing edge of the window and runs one accumulator,
// comparator and offset register per channel.
// Assumes: bp_win is synchronous to clk; channel i occupies slice i of each bus.
module bo_offset_servo
    import bo_servo_pkg::*;
#(
    parameter int NUM_CH   = DEF_CH,
    parameter int CODE_W   = DEF_CODE_W,
    parameter int TGT_W    = DEF_TGT_W,
    parameter int OFS_W    = DEF_OFS_W,
    parameter int AVG_LOG2 = DEF_AVG_LOG2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     auto_en,
    input  logic                     bp_win,
    input  logic [NUM_CH*CODE_W-1:0] adc_code,
    input  logic [NUM_CH*TGT_W-1:0]  ctl_word,
    output logic [NUM_CH*OFS_W-1:0]  ofs_word,
    output logic [NUM_CH-1:0]        lim_hit,
    output logic [NUM_CH-1:0]        tgt_bad
);
    logic win_q;
    logic win_end;

    // Remember the previous window level to find its closing edge.
    always_ff @(posedge clk) begin
        if (!rst_n) win_q <= 1'b0;
        else        win_q <= bp_win;
    end

    assign win_end = win_q && !bp_win;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic [CODE_W-1:0] avg;
        logic              full;
        logic              zero;
        dir_e              dir;

        bo_bp_avg #(.CODE_W(CODE_W), .AVG_LOG2(AVG_LOG2)) u_avg (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (!auto_en || win_end),
            .take   (auto_en && bp_win),
            .code   (adc_code[g*CODE_W +: CODE_W]),
            .avg_o  (avg),
            .full_o (full)
        );

        bo_dir_cmp #(.CODE_W(CODE_W), .TGT_W(TGT_W)) u_cmp (
            .avg    (avg),
            .target (ctl_word[g*TGT_W +: TGT_W]),
            .dir    (dir),
            .zero_o (zero)
        );

        bo_ofs_step #(.OFS_W(OFS_W)) u_step (
            .clk      (clk),
            .rst_n    (rst_n),
            .auto_en  (auto_en),
            .upd      (win_end && full),
            .dir      (dir),
            .tgt_zero (zero),
            .manual   (ctl_word[g*TGT_W +: OFS_W]),
            .ofs_o    (ofs_word[g*OFS_W +: OFS_W]),
            .lim_o    (lim_hit[g]),
            .bad_o    (tgt_bad[g])
        );
    end
endmodule

// File: rtl/bo_servo_chk.sv
// Checker for bo_offset_servo: properties over the top-level ports,
// using its own delayed copies of inputs and outputs.
// Assumes: bound to every instance of bo_offset_servo.
module bo_servo_chk #(
    parameter int NUM_CH   = 3,
    parameter int CODE_W   = 10,
    parameter int TGT_W    = 11,
    parameter int OFS_W    = 9,
    parameter int AVG_LOG2 = 2
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     auto_en,
    input logic                     bp_win,
    input logic [NUM_CH*CODE_W-1:0] adc_code,
    input logic [NUM_CH*TGT_W-1:0]  ctl_word,
    input logic [NUM_CH*OFS_W-1:0]  ofs_word,
    input logic [NUM_CH-1:0]        lim_hit,
    input logic [NUM_CH-1:0]        tgt_bad
);
    localparam int LIM = (1 << (OFS_W-1)) - 1;

    logic              win_c, end_q, auto_q;
    logic [NUM_CH-1:0] lim_q;

    // Delayed copies of window, mode and flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_c  <= 1'b0;
            end_q  <= 1'b0;
            auto_q <= 1'b0;
            lim_q  <= '0;
        end else begin
            win_c  <= bp_win;
            end_q  <= win_c && !bp_win;
            auto_q <= auto_en;
            lim_q  <= lim_hit;
        end
    end

    // Limit flags never fall outside reset.
    assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (lim_q & ~lim_hit) == '0);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_c
        logic signed [OFS_W-1:0] o_now, o_q, man_q;
        logic                    tz_q;
        int                      diff;
        int                      man_exp;

        assign o_now   = $signed(ofs_word[g*OFS_W +: OFS_W]);
        assign diff    = int'(o_now) - int'(o_q);
        assign man_exp = (int'(man_q) == -(LIM+1)) ? -LIM : int'(man_q);

        // Previous offset, manual field and zero-target condition.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                o_q   <= '0;
                man_q <= '0;
                tz_q  <= 1'b0;
            end else begin
                o_q   <= o_now;
                man_q <= $signed(ctl_word[g*TGT_W +: OFS_W]);
                tz_q  <= (ctl_word[g*TGT_W +: TGT_W] == '0);
            end
        end

        assert_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (int'(o_now) >= -LIM) && (int'(o_now) <= LIM));

        assert_one_lsb_R3: assert property (@(posedge clk) disable iff (!rst_n)
            auto_q |-> (diff >= -1 && diff <= 1));

        assert_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (auto_q && !end_q) |-> (o_now == o_q));

        assert_zero_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (auto_q && tz_q) |-> (o_now == o_q));

        assert_bad_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
            tgt_bad[g] == (auto_q && tz_q));

        assert_manual_R1: assert property (@(posedge clk) disable iff (!rst_n)
            !auto_q |-> (int'(o_now) == man_exp));
    end
endmodule

bind bo_offset_servo bo_servo_chk #(
    .NUM_CH(NUM_CH), .CODE_W(CODE_W), .TGT_W(TGT_W),
    .OFS_W(OFS_W), .AVG_LOG2(AVG_LOG2)
) u_chk (
    .clk(clk), .rst_n(rst_n), .auto_en(auto_en), .bp_win(bp_win),
    .adc_code(adc_code), .ctl_word(ctl_word), .ofs_word(ofs_word),
    .lim_hit(lim_hit), .tgt_bad(tgt_bad)
);

// File: tb/test_bo_offset_servo.sv
`timescale 1ns/1ps
module test_bo_offset_servo;
    localparam int NC = 3, CW = 10, TW = 11, OW = 9, AL = 2;
    localparam int NS = 1 << AL;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic              rst_n, auto_en, bp_win;
    logic [CW-1:0]     code_v [NC];
    logic [TW-1:0]     ctl_v  [NC];
    logic [NC*CW-1:0]  adc_code;
    logic [NC*TW-1:0]  ctl_word;
    logic [NC*OW-1:0]  ofs_word;
    logic [NC-1:0]     lim_hit, tgt_bad;

    always_comb begin
        for (int i = 0; i < NC; i++) begin
            adc_code[i*CW +: CW] = code_v[i];
            ctl_word[i*TW +: TW] = ctl_v[i];
        end
    end

    bo_offset_servo i_bo_offset_servo (
        .clk(clk), .rst_n(rst_n), .auto_en(auto_en), .bp_win(bp_win),
        .adc_code(adc_code), .ctl_word(ctl_word), .ofs_word(ofs_word),
        .lim_hit(lim_hit), .tgt_bad(tgt_bad)
    );

    // Behavioural reference state.
    int m_ofs [NC];
    int m_lim [NC];
    int m_bad [NC];
    int smp [NC][$];
    int m_win;
    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    function automatic int sx(int v, int w);
        int m = v & ((1 << w) - 1);
        return (m >= (1 << (w-1))) ? m - (1 << w) : m;
    endfunction

    // Reference next state from the inputs presented for the coming edge.
    task automatic model_step();
        int e = m_win && !bp_win;
        for (int i = 0; i < NC; i++) begin
            int tgt = sx(int'(ctl_v[i]), TW);
            int man = sx(int'(ctl_v[i]), OW);
            if (!rst_n) begin
                m_ofs[i] = 0; m_lim[i] = 0; m_bad[i] = 0; smp[i].delete();
            end else if (!auto_en) begin
                m_ofs[i] = (man == -256) ? -255 : man;
                m_bad[i] = 0;
                smp[i].delete();
            end else begin
                m_bad[i] = (tgt == 0);
                if (e) begin
                    if (smp[i].size() == NS && tgt != 0) begin
                        int s = 0;
                        int avg;
                        foreach (smp[i][k]) s += smp[i][k];
                        avg = s / NS;
                        if (avg > tgt) begin
                            m_ofs[i] = (m_ofs[i] - 1 < -255) ? -255 : m_ofs[i] - 1;
                            if (m_ofs[i] == -255) m_lim[i] = 1;
                        end else if (avg < tgt) begin
                            m_ofs[i] = (m_ofs[i] + 1 > 255) ? 255 : m_ofs[i] + 1;
                            if (m_ofs[i] == 255) m_lim[i] = 1;
                        end
                    end
                    smp[i].delete();
                end else if (bp_win && smp[i].size() < NS) begin
                    smp[i].push_back(int'(code_v[i]));
                end
            end
        end
        m_win = rst_n ? int'(bp_win) : 0;
    endtask

    task automatic compare(string tag);
        for (int i = 0; i < NC; i++) begin
            int got  = int'($signed(ofs_word[i*OW +: OW]));
            n_cmp += 3;
            if (got !== m_ofs[i]) begin
                n_bad++;
                $display("FAIL %s ch%0d offset: got %0d expected %0d", tag, i, got, m_ofs[i]);
            end
            if (int'(lim_hit[i]) !== m_lim[i]) begin
                n_bad++;
                $display("FAIL %s ch%0d lim_hit: got %0d expected %0d", tag, i, lim_hit[i], m_lim[i]);
            end
            if (int'(tgt_bad[i]) !== m_bad[i]) begin
                n_bad++;
                $display("FAIL %s ch%0d tgt_bad: got %0d expected %0d", tag, i, tgt_bad[i], m_bad[i]);
            end
        end
    endtask

    // One clock: predict, let the edge pass, compare half a period later.
    task automatic cyc(string tag);
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic line(string tag, int nwin, int ngap);
        bp_win = 1'b1;
        repeat (nwin) cyc(tag);
        bp_win = 1'b0;
        repeat (ngap) cyc(tag);
    endtask

    task automatic set_all(int c0, int c1, int c2, int t0, int t1, int t2);
        code_v[0] = CW'(c0); code_v[1] = CW'(c1); code_v[2] = CW'(c2);
        ctl_v[0]  = TW'(t0); ctl_v[1]  = TW'(t1); ctl_v[2]  = TW'(t2);
    endtask

    initial begin
        rst_n = 1'b0; auto_en = 1'b0; bp_win = 1'b0;
        set_all(0, 0, 0, 0, 0, 0);
        m_win = 0;
        for (int i = 0; i < NC; i++) begin
            m_ofs[i] = 0; m_lim[i] = 0; m_bad[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        compare("R9");

        // R1: manual pass-through, -256 raised, top bits ignored.
        set_all(5, 5, 5, 'h07B, 'h100, 'h600);
        repeat (2) cyc("R1");
        line("R1", 5, 3);

        // R10, R3, R8: load manual, then close the loop.
        set_all(5, 5, 5, 'h005, 'h1FE, 'h00A);
        cyc("R10");
        auto_en = 1'b1;
        set_all(10, 500, 0, 2, 512, 'h7FD);
        cyc("R10");
        repeat (3) line("R3", 6, 4);
        line("R8", 6, 4);

        // R2: averaging, floor, and samples beyond the set ignored.
        begin
            int seq0 [4][6] = '{'{1,2,3,4,1000,1000}, '{1,2,3,3,900,900},
                                '{3,3,3,2,0,0},      '{3,3,3,3,0,0}};
            int seq1 [6] = '{510, 514, 512, 512, 0, 1023};
            for (int l = 0; l < 4; l++) begin
                bp_win = 1'b1;
                for (int k = 0; k < 6; k++) begin
                    code_v[0] = CW'(seq0[l][k]);
                    code_v[1] = CW'(seq1[k]);
                    cyc("R2");
                end
                bp_win = 1'b0;
                code_v[0] = CW'(1023); code_v[1] = CW'(0);
                repeat (3) cyc("R2");
            end
        end

        // R4: windows too short to fill.
        set_all(900, 900, 900, 2, 512, 'h7FD);
        line("R4", 3, 3);
        line("R4", 1, 2);

        // R5, R6: drive channel 0 up and channel 2 down into saturation.
        auto_en = 1'b0;
        set_all(0, 0, 0, 'h0FA, 'h000, 'h106);
        cyc("R5");
        auto_en = 1'b1;
        set_all(0, 600, 1000, 'h1F4, 512, 'h7FD);
        repeat (9) line("R5", 5, 2);
        set_all(100, 600, 0, 2, 512, 'h3FF);
        repeat (2) line("R6", 5, 2);

        // R7: zero target holds and flags; nonzero releases.
        set_all(100, 700, 0, 2, 0, 'h3FF);
        repeat (2) line("R7", 5, 2);
        set_all(100, 700, 0, 2, 512, 'h3FF);
        line("R7", 5, 2);
        set_all(100, 700, 0, 2, 0, 'h3FF);
        cyc("R7");
        auto_en = 1'b0;
        repeat (2) cyc("R6");

        // R9: reset in the middle of operation.
        auto_en = 1'b1;
        rst_n = 1'b0;
        repeat (2) cyc("R9");
        rst_n = 1'b1;
        line("R9", 5, 2);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule